// File: doc/BRIEF.md
# Watchdog Timer with Power-Mode Handling

This block guards an 8-bit microcontroller core against runaway software. Once software arms it, a counter advances on every machine-cycle tick. If the count reaches the programmed time-out before software services the block again, the block drives a system reset pulse of fixed length. The time-out is chosen as a power of two through a 3-bit select field. A larger select value doubles the window for each step.

The block watches three sideband signals from the core: idle mode, power-down mode, and the level of the active-low wake-up interrupt pin. The counter keeps running through idle. It freezes through power-down, so software does not need to service it there. If power-down ends while the interrupt pin is still low, the counter stays frozen until the pin returns high. This keeps the watchdog from biting while the oscillator settles.

The control flow is a five-state machine:
- `ST_OFF`: disarmed.
- `ST_RUN`: counting.
- `ST_SLEEP`: frozen in power-down.
- `ST_WAKE_HOLD`: frozen after an interrupt wake until the pin is high.
- `ST_BITE`: reset asserted.

Its transitions are:
- **arm** (`ST_OFF`→`ST_RUN`): on a completed key sequence.
- **service** (`ST_RUN`→`ST_RUN`): on a completed key sequence, which clears the count.
- **expire** (`ST_RUN`→`ST_BITE`).
- **doze** (`ST_RUN`→`ST_SLEEP`): when power-down is flagged and idle is not.
- **resume** (`ST_SLEEP`→`ST_RUN`): when power-down drops with the pin high.
- **irq_wake** (`ST_SLEEP`→`ST_WAKE_HOLD`): when power-down drops with the pin low.
- **release** (`ST_WAKE_HOLD`→`ST_RUN`): when the pin goes high.
- **recover** (`ST_BITE`→`ST_OFF`): after the reset pulse ends.

Top module: `wdt_pm_top`

## Requirements
- R1: After `rst_n` is low, the select field reads 000, the enable bit (address 1, bit 0) reads 0, and `wdt_rst_o` is 0.
- R2: A write to address 0 stores `bus_wdata[2:0]` as the select value S. Reading address 0 returns S in bits 2..0 and zeros in bits 7..3.
- R3: Once armed or serviced, `wdt_rst_o` rises on the clock edge that takes the (2^(BASE_EXP+S) − 1)-th tick. It stays low after one tick fewer.
- R4: `wdt_rst_o` stays high for exactly RST_CLKS clocks. After that the enable bit reads 0, and `wdt_rst_o` stays low until the block is armed again.
- R5: Writing 0x1E and then 0xE1 to address 1 on consecutive bus writes sets the enable bit and clears the count. A completed sequence on the same edge as the final tick cancels the expiry.
- R6: Any bus write other than 0xE1 to address 1 after 0x1E aborts the sequence, and the enable bit stays 0. This includes a write to address 0.
- R7: While `pdown_i` is high (and `idle_i` low), the count does not advance. When `pdown_i` falls with `wake_irq_n` high, counting resumes from the frozen value.
- R8: If `pdown_i` falls while `wake_irq_n` is low, the count stays frozen until `wake_irq_n` is high. Counting then resumes from the frozen value.
- R9: `idle_i` does not stop the counter. When `idle_i` and `pdown_i` are both high, the block keeps counting.
- R10: Once armed, writes cannot disarm the block. Only `rst_n` or the end of a reset pulse clears the enable bit.
- R11: The count advances only on edges where `tick_i` is high. A disarmed block never asserts `wdt_rst_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low hardware reset |
| tick_i | input | 1 | Machine-cycle tick; qualifies counting |
| idle_i | input | 1 | Core is in idle mode |
| pdown_i | input | 1 | Core is in power-down mode |
| wake_irq_n | input | 1 | Level of the active-low wake-up interrupt pin |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 = time-out select, 1 = service/enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| wdt_rst_o | output | 1 | Watchdog system reset request |

## Verification
The bench builds the block with BASE_EXP = 3, which shrinks the shortest window to 7 ticks and the longest to 1023 ticks. At that size every select value, including S = 7, can be driven to expiry within a short run. This makes the exact one-tick boundary of R3 checkable at both ends of the select range. RST_CLKS keeps its default of 96, so the bench measures the full reset pulse length.

// File: rtl/wdt_pm_pkg.sv
package wdt_pm_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RUN,
        ST_SLEEP,
        ST_WAKE_HOLD,
        ST_BITE
    } wdt_state_e;

    localparam logic ADDR_SEL = 1'b0;
    localparam logic ADDR_SVC = 1'b1;

endpackage

// File: rtl/wdt_pm_regs.sv
module wdt_pm_regs
    import wdt_pm_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY_ARM = 8'h1E,
    parameter logic [DATA_W-1:0] KEY_FIRE = 8'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              en_i,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [SEL_W-1:0]  sel_o,
    output logic              svc_o
);

    localparam int PAD_W = DATA_W - SEL_W;

    logic             armed_q;
    logic [SEL_W-1:0] sel_q;

    // Key sequencer: 0x1E arms, an immediately following 0xE1 completes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            sel_q   <= '0;
        end else if (bus_we) begin
            armed_q <= (bus_addr == ADDR_SVC) && (bus_wdata == KEY_ARM);
            if (bus_addr == ADDR_SEL) begin
                sel_q <= bus_wdata[SEL_W-1:0];
            end
        end
    end

    always_comb begin
        svc_o = bus_we && (bus_addr == ADDR_SVC) && armed_q && (bus_wdata == KEY_FIRE);
    end

    always_comb begin
        if (bus_addr == ADDR_SEL) begin
            bus_rdata = {{PAD_W{1'b0}}, sel_q};
        end else begin
            bus_rdata = {{(DATA_W-1){1'b0}}, en_i};
        end
    end

    assign sel_o = sel_q;

endmodule

// File: rtl/wdt_pm_counter.sv
module wdt_pm_counter #(
    parameter int BASE_EXP = 14,
    parameter int SEL_W = 3,
    localparam int CNT_W = BASE_EXP + (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W:0]   one_sh;
    logic [CNT_W-1:0] last_q;

    // Window is 2^(BASE_EXP+S)-1 ticks; expiry fires on the tick that
    // takes the count from (window-1) to window.
    always_comb begin
        one_sh = {{CNT_W{1'b0}}, 1'b1} << (BASE_EXP + int'(sel_i));
        last_q = CNT_W'(one_sh - (CNT_W+1)'(2));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_i) begin
            count_q <= '0;
        end else if (adv_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign expire_o = adv_i && (count_q >= last_q);

endmodule

// File: rtl/wdt_pm_fsm.sv
module wdt_pm_fsm
    import wdt_pm_pkg::*;
#(
    parameter int RST_CLKS = 96,
    localparam int HOLD_W = $clog2(RST_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic idle_i,
    input  logic pdown_i,
    input  logic wake_irq_n,
    input  logic svc_i,
    input  logic expire_i,
    output logic cnt_clr_o,
    output logic cnt_adv_o,
    output logic en_o,
    output logic bite_o
);

    wdt_state_e        state_q, state_d;
    logic [HOLD_W-1:0] hold_q;
    logic              hold_done;

    assign hold_done = (hold_q == HOLD_W'(RST_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= (state_q == ST_BITE) ? hold_q + 1'b1 : '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (svc_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (svc_i)                    state_d = ST_RUN;
                else if (expire_i)            state_d = ST_BITE;
                else if (pdown_i && !idle_i)  state_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (!pdown_i) state_d = wake_irq_n ? ST_RUN : ST_WAKE_HOLD;
            end
            ST_WAKE_HOLD: begin
                if (wake_irq_n) state_d = ST_RUN;
            end
            ST_BITE: begin
                if (hold_done) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        bite_o    = (state_q == ST_BITE);
        en_o      = (state_q != ST_OFF);
        cnt_adv_o = (state_q == ST_RUN) && tick_i;
        cnt_clr_o = svc_i || (state_q == ST_OFF) || (state_q == ST_BITE);
    end

endmodule

// File: rtl/wdt_pm_top.sv
module wdt_pm_top
    import wdt_pm_pkg::*;
#(
    parameter int BASE_EXP = 14,
    parameter int SEL_W = 3,
    parameter int DATA_W = 8,
    parameter int RST_CLKS = 96,
    parameter logic [DATA_W-1:0] KEY_ARM = 8'h1E,
    parameter logic [DATA_W-1:0] KEY_FIRE = 8'hE1,
    localparam int CNT_W = BASE_EXP + (1 << SEL_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              idle_i,
    input  logic              pdown_i,
    input  logic              wake_irq_n,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_rst_o
);

    logic [SEL_W-1:0] sel;
    logic             svc;
    logic             en;
    logic             cnt_clr;
    logic             cnt_adv;
    logic             expire;

    wdt_pm_regs #(
        .SEL_W(SEL_W), .DATA_W(DATA_W), .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .en_i(en), .bus_rdata(bus_rdata),
        .sel_o(sel), .svc_o(svc)
    );

    wdt_pm_counter #(
        .BASE_EXP(BASE_EXP), .SEL_W(SEL_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .adv_i(cnt_adv),
        .sel_i(sel), .expire_o(expire)
    );

    wdt_pm_fsm #(
        .RST_CLKS(RST_CLKS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .idle_i(idle_i),
        .pdown_i(pdown_i), .wake_irq_n(wake_irq_n), .svc_i(svc),
        .expire_i(expire), .cnt_clr_o(cnt_clr), .cnt_adv_o(cnt_adv),
        .en_o(en), .bite_o(wdt_rst_o)
    );

endmodule

// File: rtl/wdt_pm_chk.sv
module wdt_pm_chk
    import wdt_pm_pkg::*;
#(
    parameter int RST_CLKS = 96,
    parameter int CNT_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input wdt_state_e       state,
    input logic [CNT_W-1:0] count,
    input logic             svc,
    input logic             wake_n,
    input logic             rst_o
);

    int unsigned hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_cnt <= 0;
        else if (rst_o) hi_cnt <= hi_cnt + 1;
        else            hi_cnt <= 0;
    end

    p_bite_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_o) |-> hi_cnt == RST_CLKS);

    p_bite_from_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> $past(state) == ST_RUN);

    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SLEEP || state == ST_WAKE_HOLD) && !svc) |=> $stable(count));

    p_hold_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE_HOLD && !wake_n) |=> state == ST_WAKE_HOLD);

    p_no_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF && state != ST_BITE) |=> state != ST_OFF);

    p_svc_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> count == '0);

endmodule

bind wdt_pm_top wdt_pm_chk #(.RST_CLKS(RST_CLKS), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(u_fsm.state_q), .count(u_cnt.count_q),
    .svc(svc), .wake_n(wake_irq_n), .rst_o(wdt_rst_o)
);

// File: tb/wdt_pm_top_test.sv
module wdt_pm_top_test;

    localparam int BASE_EXP = 3;
    localparam int RST_CLKS = 96;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       idle_i = 1'b0;
    logic       pdown_i = 1'b0;
    logic       wake_irq_n = 1'b1;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wdt_rst_o;

    int n_run = 0;
    int n_fail = 0;

    wdt_pm_top #(.BASE_EXP(BASE_EXP), .RST_CLKS(RST_CLKS)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .idle_i(idle_i),
        .pdown_i(pdown_i), .wake_irq_n(wake_irq_n), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_o(wdt_rst_o)
    );

    always #4 clk = ~clk;

    function automatic int win(input int s);
        return (1 << (BASE_EXP + s)) - 1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_i = 0; idle_i = 0; pdown_i = 0; wake_irq_n = 1; bus_we = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d, input logic tk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick_i = tk;
        @(negedge clk);
        bus_we = 1'b0; tick_i = 1'b0;
    endtask

    task automatic rd(input logic a, output int v);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            @(negedge clk);
        end
        tick_i = 1'b0;
    endtask

    task automatic arm();
        wr(1'b1, 8'h1E, 1'b0);
        wr(1'b1, 8'hE1, 1'b0);
    endtask

    task automatic wait_bite(input string tag);
        int len = 0;
        int v;
        while (wdt_rst_o && len < 1000) begin
            len++;
            @(negedge clk);
        end
        chk({tag, " pulse length"}, len, RST_CLKS);
        rd(1'b1, v);
        chk({tag, " enable cleared"}, v, 0);
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        chk("R1 rst_o", int'(wdt_rst_o), 0);
        rd(1'b0, v); chk("R1 select", v, 0);
        rd(1'b1, v); chk("R1 enable", v, 0);
    endtask

    task automatic t_disabled();
        do_reset();
        ticks(40);
        chk("R11 disarmed no bite", int'(wdt_rst_o), 0);
    endtask

    task automatic t_abort();
        int v;
        do_reset();
        wr(1'b1, 8'h1E, 1'b0); wr(1'b1, 8'h55, 1'b0); wr(1'b1, 8'hE1, 1'b0);
        rd(1'b1, v); chk("R6 abort by other byte", v, 0);
        wr(1'b1, 8'h1E, 1'b0); wr(1'b0, 8'h00, 1'b0); wr(1'b1, 8'hE1, 1'b0);
        rd(1'b1, v); chk("R6 abort by select write", v, 0);
    endtask

    task automatic t_timeout_s0();
        int v;
        do_reset();
        arm();
        rd(1'b1, v); chk("R5 armed", v, 1);
        ticks(win(0) - 1);
        chk("R3 S0 one short", int'(wdt_rst_o), 0);
        ticks(1);
        chk("R3 S0 expiry", int'(wdt_rst_o), 1);
        wait_bite("R4 S0");
        ticks(20);
        chk("R4 stays low after pulse", int'(wdt_rst_o), 0);
    endtask

    task automatic t_select();
        int v;
        do_reset();
        wr(1'b0, 8'hFA, 1'b0);
        rd(1'b0, v); chk("R2 reserved read zero", v, 2);
        arm();
        ticks(win(2) - 1);
        chk("R3 S2 one short", int'(wdt_rst_o), 0);
        ticks(1);
        chk("R3 S2 expiry", int'(wdt_rst_o), 1);
        wait_bite("R4 S2");
        wr(1'b0, 8'h07, 1'b0);
        arm();
        ticks(win(7) - 1);
        chk("R3 S7 one short", int'(wdt_rst_o), 0);
        ticks(1);
        chk("R3 S7 expiry", int'(wdt_rst_o), 1);
        wait_bite("R4 S7");
    endtask

    task automatic t_tick_gate();
        do_reset();
        arm();
        repeat (200) @(negedge clk);
        chk("R11 no tick no count", int'(wdt_rst_o), 0);
        ticks(win(0) - 1);
        chk("R11 ticks only", int'(wdt_rst_o), 0);
        ticks(1);
        chk("R11 fires on last tick", int'(wdt_rst_o), 1);
        wait_bite("R4 tick gate");
    endtask

    task automatic t_idle();
        do_reset();
        idle_i = 1'b1;
        pdown_i = 1'b1;
        arm();
        ticks(win(0));
        chk("R9 idle keeps counting", int'(wdt_rst_o), 1);
        idle_i = 1'b0;
        pdown_i = 1'b0;
        wait_bite("R4 idle");
    endtask

    task automatic t_service();
        do_reset();
        arm();
        ticks(win(0) - 2);
        wr(1'b1, 8'h1E, 1'b1);
        wr(1'b1, 8'hE1, 1'b1);
        chk("R5 service beats expiry", int'(wdt_rst_o), 0);
        ticks(win(0) - 1);
        chk("R5 count cleared", int'(wdt_rst_o), 0);
        ticks(1);
        chk("R5 fires after full window", int'(wdt_rst_o), 1);
        wait_bite("R4 service");
    endtask

    task automatic t_no_disable();
        int v;
        do_reset();
        arm();
        wr(1'b1, 8'h00, 1'b0);
        wr(1'b1, 8'hE1, 1'b0);
        wr(1'b0, 8'h00, 1'b0);
        rd(1'b1, v); chk("R10 still armed", v, 1);
        ticks(win(0));
        chk("R10 still bites", int'(wdt_rst_o), 1);
        wait_bite("R4 no disable");
    endtask

    task automatic t_pdown_resume();
        do_reset();
        arm();
        ticks(4);
        pdown_i = 1'b1;
        @(negedge clk);
        ticks(100);
        chk("R7 frozen in power-down", int'(wdt_rst_o), 0);
        pdown_i = 1'b0;
        @(negedge clk);
        ticks(win(0) - 5);
        chk("R7 resumed one short", int'(wdt_rst_o), 0);
        ticks(1);
        chk("R7 resumed expiry", int'(wdt_rst_o), 1);
        wait_bite("R4 pdown");
    endtask

    task automatic t_pdown_irq();
        do_reset();
        arm();
        ticks(4);
        pdown_i = 1'b1;
        @(negedge clk);
        wake_irq_n = 1'b0;
        @(negedge clk);
        pdown_i = 1'b0;
        @(negedge clk);
        ticks(50);
        chk("R8 held while pin low", int'(wdt_rst_o), 0);
        wake_irq_n = 1'b1;
        @(negedge clk);
        ticks(win(0) - 5);
        chk("R8 released one short", int'(wdt_rst_o), 0);
        ticks(1);
        chk("R8 released expiry", int'(wdt_rst_o), 1);
        wait_bite("R4 irq wake");
    endtask

    task automatic t_hw_reset();
        int v;
        do_reset();
        wr(1'b0, 8'h05, 1'b0);
        arm();
        ticks(3);
        do_reset();
        rd(1'b0, v); chk("R1 select after reset", v, 0);
        rd(1'b1, v); chk("R1 enable after reset", v, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_disabled();
        t_abort();
        t_timeout_s0();
        t_select();
        t_tick_gate();
        t_idle();
        t_service();
        t_no_disable();
        t_pdown_resume();
        t_pdown_irq();
        t_hw_reset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule